// File: doc/BRIEF.md
# Load Data Byte Formatter

This block sits in the writeback stage and turns a raw 64-bit doubleword from the data cache into the value written to the register file. One output byte of eight byte lanes can take any input lane. A single selection step therefore handles both the rotation by the byte offset and an optional byte reversal within the access. Per-lane logic then clears the bytes above the access size or fills them with the sign of the top loaded byte.

A load that runs past the end of a doubleword arrives as two beats. On the first beat the rotated bytes are held in a register. On the second beat the block merges the held bytes with the rotated bytes of the next doubleword. Byte-reversed loads can also be split this way. When requested, the block also compares the 64-bit result with zero and produces a 4-bit condition field.

Top module: `load_formatter`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `dout` is all zeros and `cr_out` is 0000.
- R2: `out_valid` is high in the cycle after an `in_valid` beat that completes an access, and low in every other cycle. A beat completes an access when it is a second half, or when the access is not split.
- R3: The access size code maps 00 to 1 byte, 01 to 2, 10 to 4 and 11 to 8. Lane k of `din` is memory byte k (little-endian). Without reversal, result byte j (bits 8j+7:8j) is memory byte `byte_off`+j, for j below the size.
- R4: With `rev_en`=1, result byte j is memory byte `byte_off`+n-1-j, where n is the access size in bytes.
- R5: With `sext_en`=0, every result byte at position n or above is zero.
- R6: With `sext_en`=1, every result byte at position n or above equals eight copies of bit 7 of result byte n-1.
- R7: An access is split when `byte_off`+n exceeds 8. The first beat has `second_half`=0 and carries the doubleword at the lower address; it produces no output. The second beat has `second_half`=1 and carries the next doubleword. In the combined result, memory bytes 8 and up come from the second beat.
- R8: Split accesses give correct results with `rev_en`=1, using the byte order of R4 across both doublewords.
- R9: The held doubleword loads only on the first beat of a split access. A complete access that arrives between the two beats of a split access leaves the held doubleword unchanged.
- R10: With `rc_en`=1, `cr_out` is {LT,GT,EQ,SO}. LT, GT and EQ report a negative, positive or zero 64-bit result, and SO copies `so_in` from the completing beat. With `rc_en`=0, `cr_out` is 0000.
- R11: In a cycle that follows a cycle without `in_valid`, `dout` and `cr_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat present this cycle |
| din | input | 64 | Doubleword from memory, lane k = byte k |
| acc_size | input | 2 | Access size code (1, 2, 4 or 8 bytes) |
| byte_off | input | 3 | Byte offset of the access in the doubleword |
| rev_en | input | 1 | Reverse bytes within the access |
| sext_en | input | 1 | Sign-extend instead of zero-filling |
| second_half | input | 1 | Beat is the second doubleword of a split access |
| rc_en | input | 1 | Produce the condition field |
| so_in | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result valid |
| dout | output | 64 | Formatted result |
| cr_out | output | 4 | Condition field {LT,GT,EQ,SO} |

## Verification
The hardest case to reach is a split access whose held bytes must survive an unrelated complete load arriving between its two beats. The held register must stay unchanged, and the second beat must still merge with the bytes from the original first beat. The bench reaches this with a dedicated sequence of three beats: the first half of a split, then an aligned load with different data and controls, then the second half. It then checks both results. Apart from that sequence, every size, offset, reversal and sign setting is swept against a byte-array model. Each split case goes through both beats.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  // access size codes: bytes = 1 << code
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } acc_size_e;

  // condition field bit positions
  localparam int CR_LT = 3;
  localparam int CR_GT = 2;
  localparam int CR_EQ = 1;
  localparam int CR_SO = 0;
endpackage

// File: rtl/ldfmt_rotator.sv
module ldfmt_rotator #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 8,
  localparam int DW    = BYTE_W * LANES,
  localparam int OFFW  = $clog2(LANES)
) (
  input  logic [DW-1:0]   din,
  input  logic [OFFW-1:0] offset,
  input  logic [OFFW:0]   nbytes,
  input  logic            rev,
  output logic [DW-1:0]   rot,
  output logic [LANES-1:0] from_next
);
  // one select-any-lane mux per output lane; rotation and reversal share it
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [OFFW:0] idx;
    always_comb begin
      if (rev) idx = nbytes - (OFFW+1)'(1) - (OFFW+1)'(k) + {1'b0, offset};
      else     idx = (OFFW+1)'(k) + {1'b0, offset};
    end
    assign rot[k*BYTE_W +: BYTE_W] = din[idx[OFFW-1:0]*BYTE_W +: BYTE_W];
    assign from_next[k]            = idx[OFFW];
  end
endmodule

// File: rtl/ldfmt_hold.sv
module ldfmt_hold #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/ldfmt_finish.sv
module ldfmt_finish #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 8,
  localparam int DW    = BYTE_W * LANES,
  localparam int OFFW  = $clog2(LANES)
) (
  input  logic [DW-1:0]    cur_rot,
  input  logic [DW-1:0]    held_rot,
  input  logic [LANES-1:0] from_next,
  input  logic             splice,
  input  logic [OFFW:0]    nbytes,
  input  logic             sext,
  output logic [DW-1:0]    result
);
  logic [DW-1:0] merged;
  logic          sign_bit;

  // splice: lanes sourced from the first doubleword come from the held copy
  for (genvar k = 0; k < LANES; k++) begin : g_merge
    assign merged[k*BYTE_W +: BYTE_W] = (splice && !from_next[k]) ?
        held_rot[k*BYTE_W +: BYTE_W] : cur_rot[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    sign_bit = 1'b0;
    for (int k = 0; k < LANES; k++)
      if ((OFFW+1)'(k) == nbytes - (OFFW+1)'(1)) sign_bit = merged[k*BYTE_W + BYTE_W - 1];
  end

  // trim or sign-fill lanes above the access size
  for (genvar k = 0; k < LANES; k++) begin : g_trim
    assign result[k*BYTE_W +: BYTE_W] = ((OFFW+1)'(k) < nbytes) ?
        merged[k*BYTE_W +: BYTE_W] : {BYTE_W{sext & sign_bit}};
  end
endmodule

// File: rtl/ldfmt_cond.sv
module ldfmt_cond #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] value,
  input  logic          enable,
  input  logic          so,
  output logic [3:0]    cr
);
  import ldfmt_pkg::*;
  logic zero;
  assign zero = (value == '0);

  always_comb begin
    cr = '0;
    if (enable) begin
      cr[CR_LT] = value[DW-1];
      cr[CR_GT] = !value[DW-1] && !zero;
      cr[CR_EQ] = zero;
      cr[CR_SO] = so;
    end
  end
endmodule

// File: rtl/load_formatter.sv
module load_formatter #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 8,
  localparam int DW    = BYTE_W * LANES,
  localparam int OFFW  = $clog2(LANES),
  localparam int SZW   = $clog2(OFFW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   din,
  input  logic [SZW-1:0]  acc_size,
  input  logic [OFFW-1:0] byte_off,
  input  logic            rev_en,
  input  logic            sext_en,
  input  logic            second_half,
  input  logic            rc_en,
  input  logic            so_in,
  output logic            out_valid,
  output logic [DW-1:0]   dout,
  output logic [3:0]      cr_out
);
  logic [OFFW:0]    nbytes;
  logic [OFFW+1:0]  span;
  logic             split;
  logic             hold_load;
  logic             emit;
  logic [DW-1:0]    rot;
  logic [DW-1:0]    held;
  logic [LANES-1:0] from_next;
  logic [DW-1:0]    result;
  logic [3:0]       cr_d;

  logic             valid_d;
  logic [DW-1:0]    dout_d;
  logic [3:0]       cr_nx;

  assign nbytes    = (OFFW+1)'(1) << acc_size;
  assign span      = {2'b00, byte_off} + {1'b0, nbytes};
  assign split     = span > (OFFW+2)'(LANES);
  assign hold_load = in_valid && !second_half && split;
  assign emit      = in_valid && (second_half || !split);

  ldfmt_rotator #(.BYTE_W(BYTE_W), .LANES(LANES)) u_rot (
    .din(din), .offset(byte_off), .nbytes(nbytes), .rev(rev_en),
    .rot(rot), .from_next(from_next)
  );

  ldfmt_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .d(rot), .q(held)
  );

  ldfmt_finish #(.BYTE_W(BYTE_W), .LANES(LANES)) u_fin (
    .cur_rot(rot), .held_rot(held), .from_next(from_next),
    .splice(second_half), .nbytes(nbytes), .sext(sext_en), .result(result)
  );

  ldfmt_cond #(.DW(DW)) u_cond (
    .value(result), .enable(rc_en), .so(so_in), .cr(cr_d)
  );

  always_comb begin
    valid_d = emit;
    dout_d  = dout;
    cr_nx   = cr_out;
    if (emit) begin
      dout_d = result;
      cr_nx  = cr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= '0;
      cr_out    <= '0;
    end else begin
      out_valid <= valid_d;
      dout      <= dout_d;
      cr_out    <= cr_nx;
    end
  end
endmodule

// File: rtl/ldfmt_checker.sv
module ldfmt_checker #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 8,
  localparam int DW    = BYTE_W * LANES,
  localparam int OFFW  = $clog2(LANES),
  localparam int SZW   = $clog2(OFFW + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [DW-1:0]   din,
  input logic [SZW-1:0]  acc_size,
  input logic [OFFW-1:0] byte_off,
  input logic            rev_en,
  input logic            sext_en,
  input logic            second_half,
  input logic            rc_en,
  input logic            so_in,
  input logic            out_valid,
  input logic [DW-1:0]   dout,
  input logic [3:0]      cr_out
);
  // R2: a result needs a beat in the previous cycle
  a_r2_valid_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R5: single-byte zero-filled load leaves upper lanes clear
  a_r5_byte_trim: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(acc_size == '0 && !sext_en)) |-> (dout[DW-1:BYTE_W] == '0));

  // R6: single-byte signed load fills upper lanes with its sign
  a_r6_byte_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(acc_size == '0 && sext_en)) |->
      (dout[DW-1:BYTE_W] == {(DW-BYTE_W){dout[BYTE_W-1]}}));

  // R10: exactly one of LT/GT/EQ and EQ matches a zero result
  a_r10_cr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(rc_en)) |-> ($countones(cr_out[3:1]) == 1 && cr_out[1] == (dout == '0)));

  a_r10_cr_so: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(rc_en)) |-> (cr_out[0] == $past(so_in)));

  a_r10_cr_off: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(rc_en)) |-> (cr_out == 4'b0000));

  // R11: idle cycle keeps the result
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(dout) && $stable(cr_out)));
endmodule

bind load_formatter ldfmt_checker #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (.*);

// File: tb/sim_load_formatter.sv
module sim_load_formatter;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] din;
  logic [1:0]  acc_size;
  logic [2:0]  byte_off;
  logic        rev_en, sext_en, second_half, rc_en, so_in;
  logic        out_valid;
  logic [63:0] dout;
  logic [3:0]  cr_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  load_formatter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .din(din),
    .acc_size(acc_size), .byte_off(byte_off), .rev_en(rev_en),
    .sext_en(sext_en), .second_half(second_half), .rc_en(rc_en),
    .so_in(so_in), .out_valid(out_valid), .dout(dout), .cr_out(cr_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // byte-array model of the formatted result
  function automatic logic [63:0] model(input logic [63:0] d0, input logic [63:0] d1,
                                        input int n, input int off, input bit rev, input bit sx);
    logic [7:0] mem [16];
    logic [7:0] val [8];
    logic [7:0] res [8];
    logic [63:0] r;
    for (int i = 0; i < 8; i++) begin
      mem[i]   = d0[8*i +: 8];
      mem[i+8] = d1[8*i +: 8];
    end
    for (int j = 0; j < 8; j++) val[j] = (j < n) ? mem[off + j] : 8'h00;
    for (int k = 0; k < 8; k++) res[k] = (k < n) ? (rev ? val[n-1-k] : val[k]) : 8'h00;
    for (int k = 0; k < 8; k++)
      if (k >= n) res[k] = (sx && res[n-1][7]) ? 8'hFF : 8'h00;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = res[k];
    return r;
  endfunction

  function automatic logic [3:0] cr_model(input logic [63:0] v, input bit rc, input bit so);
    if (!rc) return 4'b0000;
    if (v[63]) return {3'b100, so};
    if (v == 64'd0) return {3'b001, so};
    return {3'b010, so};
  endfunction

  task automatic drive(input logic [63:0] d, input int sz, input int off, input bit rev,
                       input bit sx, input bit sh, input bit rc, input bit so);
    in_valid = 1'b1; din = d; acc_size = 2'(sz); byte_off = 3'(off);
    rev_en = rev; sext_en = sx; second_half = sh; rc_en = rc; so_in = so;
  endtask

  task automatic idle();
    in_valid = 1'b0; second_half = 1'b0;
  endtask

  // one full access; checks result, condition and valid timing
  task automatic access(input logic [63:0] d0, input logic [63:0] d1, input int sz,
                        input int off, input bit rev, input bit sx, input bit rc,
                        input bit so, input string tag);
    int n;
    logic [63:0] exp;
    n = 1 << sz;
    exp = model(d0, d1, n, off, rev, sx);
    drive(d0, sz, off, rev, sx, 1'b0, rc, so);
    @(negedge clk);
    if (off + n > 8) begin
      check({tag, " R7 no output on first half"}, {63'd0, out_valid}, 64'd0);
      drive(d1, sz, off, rev, sx, 1'b1, rc, so);
      @(negedge clk);
    end
    idle();
    check({tag, " R2 valid"}, {63'd0, out_valid}, 64'd1);
    check(tag, dout, exp);
    check({tag, " R10 cr"}, {60'd0, cr_out}, {60'd0, cr_model(exp, rc, so)});
    @(negedge clk);
    check({tag, " R2 valid drops"}, {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle(); din = '0; acc_size = '0; byte_off = '0;
    rev_en = 0; sext_en = 0; rc_en = 0; so_in = 0;
    repeat (3) @(negedge clk);
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 dout", dout, 64'd0);
    check("R1 cr_out", {60'd0, cr_out}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // every size/offset/reverse/sign setting; covers R3 R4 R5 R6 R7 R8
  task automatic t_sweep();
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 8; off++)
        for (int rv = 0; rv < 2; rv++)
          for (int sx = 0; sx < 2; sx++) begin
            logic [63:0] d0, d1;
            string tag;
            d0 = 64'h8F71_E253_C435_A617 ^ {8{8'(off * 37 + sz * 11 + sx * 128)}};
            d1 = 64'h19F8_2BDA_3CBE_4D90 ^ {8{8'(off * 53 + rv * 128)}};
            if (off + (1 << sz) > 8) tag = rv ? "R8 split reversed" : "R7 split";
            else tag = rv ? "R4 reversed" : "R3 rotate";
            tag = {tag, sx ? " R6" : " R5"};
            access(d0, d1, sz, off, rv[0], sx[0], 1'b0, 1'b0, tag);
          end
  endtask

  task automatic t_cond();
    access(64'h0000_0000_0000_0080, '0, 0, 0, 0, 1, 1, 0, "R10 negative");
    access(64'h0000_0000_0000_0080, '0, 0, 0, 0, 0, 1, 1, "R10 positive so");
    access(64'h00FF_0000_0000_0000, '0, 1, 0, 0, 1, 1, 1, "R10 zero");
    access(64'h1122_3344_5566_7788, 64'h0, 3, 4, 0, 0, 1, 0, "R10 split");
  endtask

  // split first half, unrelated complete load, then second half
  task automatic t_hold();
    logic [63:0] d0, d1, x;
    d0 = 64'hA1B2_C3D4_E5F6_0718;
    d1 = 64'h2938_4756_6574_8392;
    x  = 64'h5555_AAAA_1234_FEDC;
    drive(d0, 3, 5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    drive(x, 2, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 between valid", {63'd0, out_valid}, 64'd1);
    check("R9 between data", dout, model(x, 64'd0, 4, 0, 1, 0));
    drive(d1, 3, 5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    idle();
    check("R9 split after interleave", dout, model(d0, d1, 8, 5, 0, 0));
    @(negedge clk);
  endtask

  task automatic t_idle();
    logic [63:0] last;
    access(64'hFEDC_BA98_7654_3210, '0, 2, 2, 0, 1, 1, 1, "R11 setup");
    last = dout;
    din = ~din; byte_off = 3'd1; rc_en = 0;
    repeat (3) @(negedge clk);
    check("R11 dout held", dout, last);
    check("R11 no valid", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_cond();
    t_hold();
    t_idle();
    done = 1;
    finish_run();
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end
endmodule